// File: doc/BRIEF.md
# X-Bus Peripheral Decoder and Transceiver Control

This block watches the ISA address lines (SA[16:0] and LA[23:17]) and the four ISA command strobes. It produces the chip selects for the small peripherals that sit on an 8-bit buffered X-Bus: the boot firmware memory, the keyboard controller, an embedded microcontroller and the real-time clock. It also produces the timed address-latch strobe of the real-time clock, and it drives the direction and output-enable controls of the transceiver between the X-Bus and the system data bus.

Each device decode has its own enable bit. A device whose enable is clear gets neither a select nor a transceiver enable. The transceiver direction follows any I/O read, a firmware-space memory read, or the DMA acknowledge during DMA reads. The output enable is released at the end of the command for PCI-initiated cycles. For ISA-master cycles it is held until the address stops decoding. Five of the outputs can each be taken over as a general-purpose output.

Top module: `xbus_decoder`

## Requirements
- R1: With the command of the cycle active, kbc_cs_n is low for an I/O read or write to 16'h0060 or 16'h0064, mc_cs_n for 16'h0062 or 16'h0066, and rtc_cs_n for 16'h0071. All address bits above bit 15 (SA[16] and LA) must be zero. The device's bit of dev_en must be 1 (bit 1 keyboard, bit 2 microcontroller, bit 3 clock). Otherwise the select is high.
- R2: When iow_n is seen falling at a clock edge while the address is 16'h0070, rtc_ale is high from that edge for exactly 2 clock cycles. A write to any other port produces no strobe.
- R3: bios_cs_n is low while memr_n or memw_n is low, dev_en bit 0 is 1, dma_act is 0, and the 24-bit address {LA,SA} lies in F0000h–FFFFFh, or in E0000h–FFFFFh when bios_wide is 1, or in the matching alias at the top of the space with LA all ones. It is never low while dma_act is 1.
- R4: With dma_act at 0, xdir_n is low while ior_n is low, whatever the address. It is also low while memr_n is low on an enabled firmware decode. Otherwise it is high.
- R5: With dma_act at 1, xdir_n equals dack_n.
- R6: xoe_n goes low while a command is active on an address that decodes to a device whose enable bit is 1. A hit on a disabled device leaves xoe_n high.
- R7: With isa_master at 0, xoe_n is high as soon as the command ends. With isa_master at 1, after a clock edge that saw the command active, xoe_n stays low until the address stops decoding.
- R8: When gpo_sel[i] is 1, the pin with index i shows gpo_val[i]. The pins are indexed 0 rtc_ale, 1 rtc_cs_n, 2 kbc_cs_n, 3 xdir_n, 4 xoe_n.
- R9: While rst_n is low, every output is high except rtc_ale, which is low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa | input | 17 | System address SA[16:0] |
| la | input | 7 | Latched address LA[23:17] |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| dma_act | input | 1 | DMA cycle in progress |
| dack_n | input | 1 | DMA acknowledge, active low |
| isa_master | input | 1 | 1 = ISA-master cycle, 0 = PCI-initiated |
| dev_en | input | 4 | Decode enables: 0 firmware, 1 keyboard, 2 microcontroller, 3 clock |
| bios_wide | input | 1 | Extend firmware range down to E0000h |
| gpo_sel | input | 5 | Per-pin general-purpose output select |
| gpo_val | input | 5 | Per-pin general-purpose output value |
| bios_cs_n | output | 1 | Firmware memory select |
| kbc_cs_n | output | 1 | Keyboard controller select |
| mc_cs_n | output | 1 | Microcontroller select |
| rtc_cs_n | output | 1 | Real-time clock data select |
| rtc_ale | output | 1 | Real-time clock address latch strobe |
| xdir_n | output | 1 | Transceiver direction, low = toward system bus |
| xoe_n | output | 1 | Transceiver output enable, active low |

## Verification
Some properties are checked on every cycle:
- The device selects are mutually exclusive.
- No firmware select is raised during DMA.
- The transceiver is never enabled without an enabled address hit.
- Every I/O read outside DMA turns the transceiver toward the system bus.
- Every strobe pulse lasts at least its programmed length.

Other behaviour is shown only by the bench's sweeps:
- The exact address ranges, including the aliases and the wide firmware option.
- The exact two-cycle strobe.
- The difference in output-enable hold between ISA-master and PCI cycles.
- The general-purpose takeover of each pin.
- The forced levels during reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   localparam int NUM_DEV  = 4;
   localparam int DEV_BIOS = 0;
   localparam int DEV_KBC  = 1;
   localparam int DEV_MC   = 2;
   localparam int DEV_RTC  = 3;

   localparam int NUM_PIN  = 5;
   localparam int PIN_ALE  = 0;
   localparam int PIN_RTC  = 1;
   localparam int PIN_KBC  = 2;
   localparam int PIN_XDIR = 3;
   localparam int PIN_XOE  = 4;
   // level of each reusable pin while reset is held
   localparam logic [NUM_PIN-1:0] PIN_IDLE = 5'b11110;
endpackage

// File: rtl/xbus_addr_dec.sv
module xbus_addr_dec
   import xbus_pkg::*;
#(
   parameter int          IO_W      = 16,
   parameter logic [15:0] KBC_PORT0 = 16'h0060,
   parameter logic [15:0] KBC_PORT1 = 16'h0064,
   parameter logic [15:0] MC_PORT0  = 16'h0062,
   parameter logic [15:0] MC_PORT1  = 16'h0066,
   parameter logic [15:0] RTC_DATA  = 16'h0071,
   parameter logic [15:0] RTC_INDEX = 16'h0070
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [16:0]        sa,
   input  logic [23:17]       la,
   input  logic               io_cmd,
   input  logic               mem_cmd,
   input  logic               dma_act,
   input  logic [NUM_DEV-1:0] dev_en,
   input  logic               bios_wide,
   output logic [NUM_DEV-1:0] hit,
   output logic [NUM_DEV-1:0] sel,
   output logic               index_hit
);
   localparam int ADDR_W = 24;

   initial begin
      assert (IO_W >= 8 && IO_W <= 16) else $fatal(1, "IO_W out of range");
   end

   logic [ADDR_W-1:0] addr;
   logic              io_top_zero;
   logic [IO_W-1:0]   io_low;
   logic              bios_range;
   logic [NUM_DEV-1:0] raw;

   assign addr        = {la, sa};
   assign io_low      = sa[IO_W-1:0];
   assign io_top_zero = (addr >> IO_W) == '0;

   // firmware window: bits 19:17 all ones, bit 16 set unless the wide option
   assign bios_range = ((addr[23:20] == 4'h0) || (addr[23:20] == 4'hF)) &&
                       (addr[19:17] == 3'b111) && (addr[16] || bios_wide);

   always_comb begin
      raw[DEV_BIOS] = bios_range;
      raw[DEV_KBC]  = io_top_zero && ((io_low == KBC_PORT0[IO_W-1:0]) ||
                                      (io_low == KBC_PORT1[IO_W-1:0]));
      raw[DEV_MC]   = io_top_zero && ((io_low == MC_PORT0[IO_W-1:0]) ||
                                      (io_low == MC_PORT1[IO_W-1:0]));
      raw[DEV_RTC]  = io_top_zero && (io_low == RTC_DATA[IO_W-1:0]);
   end

   assign index_hit = io_top_zero && (io_low == RTC_INDEX[IO_W-1:0]);

   genvar d;
   generate
      for (d = 0; d < NUM_DEV; d++) begin : g_dev
         if (d == DEV_BIOS) begin : g_mem
            assign hit[d] = raw[d] && dev_en[d] && !dma_act;
            assign sel[d] = hit[d] && mem_cmd;
         end else begin : g_io
            assign hit[d] = raw[d] && dev_en[d];
            assign sel[d] = hit[d] && io_cmd;
         end
      end
   endgenerate

   assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   assert_bios_no_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_act |-> !sel[DEV_BIOS]);
endmodule

// File: rtl/xbus_ale_timer.sv
module xbus_ale_timer #(
   parameter int ALE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic iow_n,
   input  logic index_hit,
   output logic ale
);
   localparam int CW = $clog2(ALE_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(ALE_CYCLES);

   initial begin
      assert (ALE_CYCLES >= 1) else $fatal(1, "ALE_CYCLES must be positive");
   end

   logic          iow_q;
   logic [CW-1:0] cnt;
   logic          start;

   assign start = iow_q && !iow_n && index_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iow_q <= 1'b1;
         cnt   <= '0;
      end else begin
         iow_q <= iow_n;
         if (start)
            cnt <= LOAD;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end

   assign ale = (cnt != '0);

   // pulse length watch, independent of the load counter
   logic [CW:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= '0;
      else if (!ale) run_len <= '0;
      else if (run_len != '1) run_len <= run_len + 1'b1;
   end

   assert_ale_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ale);
   assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |-> (run_len >= (CW+1)'(ALE_CYCLES)));
endmodule

// File: rtl/xbus_xcvr_ctl.sv
module xbus_xcvr_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic isa_master,
   input  logic dma_act,
   input  logic dack_n,
   input  logic ior_n,
   input  logic memr_n,
   input  logic bios_hit,
   input  logic sel_any,
   input  logic hit_any,
   output logic xdir_f,
   output logic xoe_f
);
   logic held;

   // ISA-master cycles keep the enable until the address leaves the decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b0;
      else        held <= isa_master && hit_any && (held || sel_any);
   end

   always_comb begin
      if (dma_act) xdir_f = dack_n;
      else         xdir_f = !(!ior_n || (!memr_n && bios_hit));
   end

   assign xoe_f = !(sel_any || (held && isa_master && hit_any));

   assert_xoe_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xoe_f |-> hit_any);
   assert_xdir_ioread_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_act && !ior_n) |-> !xdir_f);
endmodule

// File: rtl/xbus_decoder.sv
module xbus_decoder
   import xbus_pkg::*;
#(
   parameter int ALE_CYCLES = 2,
   parameter int IO_W       = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [16:0]   sa,
   input  logic [23:17]  la,
   input  logic          ior_n,
   input  logic          iow_n,
   input  logic          memr_n,
   input  logic          memw_n,
   input  logic          dma_act,
   input  logic          dack_n,
   input  logic          isa_master,
   input  logic [3:0]    dev_en,
   input  logic          bios_wide,
   input  logic [4:0]    gpo_sel,
   input  logic [4:0]    gpo_val,
   output logic          bios_cs_n,
   output logic          kbc_cs_n,
   output logic          mc_cs_n,
   output logic          rtc_cs_n,
   output logic          rtc_ale,
   output logic          xdir_n,
   output logic          xoe_n
);
   logic [NUM_DEV-1:0] hit, sel;
   logic               index_hit, ale_f, xdir_f, xoe_f;
   logic [NUM_PIN-1:0] fn, pin;

   xbus_addr_dec #(.IO_W(IO_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .sa(sa), .la(la),
      .io_cmd(!ior_n || !iow_n), .mem_cmd(!memr_n || !memw_n),
      .dma_act(dma_act), .dev_en(dev_en), .bios_wide(bios_wide),
      .hit(hit), .sel(sel), .index_hit(index_hit)
   );

   xbus_ale_timer #(.ALE_CYCLES(ALE_CYCLES)) u_ale (
      .clk(clk), .rst_n(rst_n), .iow_n(iow_n), .index_hit(index_hit),
      .ale(ale_f)
   );

   xbus_xcvr_ctl u_xcvr (
      .clk(clk), .rst_n(rst_n), .isa_master(isa_master), .dma_act(dma_act),
      .dack_n(dack_n), .ior_n(ior_n), .memr_n(memr_n),
      .bios_hit(hit[DEV_BIOS]), .sel_any(|sel), .hit_any(|hit),
      .xdir_f(xdir_f), .xoe_f(xoe_f)
   );

   always_comb begin
      fn           = '0;
      fn[PIN_ALE]  = ale_f;
      fn[PIN_RTC]  = !sel[DEV_RTC];
      fn[PIN_KBC]  = !sel[DEV_KBC];
      fn[PIN_XDIR] = xdir_f;
      fn[PIN_XOE]  = xoe_f;
   end

   genvar p;
   generate
      for (p = 0; p < NUM_PIN; p++) begin : g_pin
         assign pin[p] = !rst_n ? PIN_IDLE[p] : (gpo_sel[p] ? gpo_val[p] : fn[p]);
      end
   endgenerate

   assign rtc_ale   = pin[PIN_ALE];
   assign rtc_cs_n  = pin[PIN_RTC];
   assign kbc_cs_n  = pin[PIN_KBC];
   assign xdir_n    = pin[PIN_XDIR];
   assign xoe_n     = pin[PIN_XOE];
   assign bios_cs_n = !rst_n || !sel[DEV_BIOS];
   assign mc_cs_n   = !rst_n || !sel[DEV_MC];
endmodule

// File: tb/sim_xbus_decoder.sv
module sim_xbus_decoder;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [16:0] sa = '0;
   logic [23:17] la = '0;
   logic ior_n = 1, iow_n = 1, memr_n = 1, memw_n = 1;
   logic dma_act = 0, dack_n = 1, isa_master = 0, bios_wide = 0;
   logic [3:0] dev_en = 4'hF;
   logic [4:0] gpo_sel = '0, gpo_val = '0;
   logic bios_cs_n, kbc_cs_n, mc_cs_n, rtc_cs_n, rtc_ale, xdir_n, xoe_n;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xbus_decoder u0 (.*);

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic bios_exp(input logic [6:0] l, input logic s16, input logic w);
      return ((l[6:3] == 4'h0) || (l[6:3] == 4'hF)) && (l[2:0] == 3'b111) && (s16 || w);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R9: forced idle levels during reset, even with a hit and GPO selected
      sa = 17'h60; ior_n = 0; gpo_sel = 5'h1F; gpo_val = 5'h01;
      #(CLK_PERIOD*2 + 1);
      chk("R9", {bios_cs_n, kbc_cs_n, mc_cs_n, rtc_cs_n, rtc_ale, xdir_n, xoe_n},
          7'b1111011);
      @(negedge clk); ior_n = 1; gpo_sel = 0; gpo_val = 0; sa = 0;
      rst_n = 1;
      @(negedge clk);
      chk("R9 idle after", {bios_cs_n, kbc_cs_n, mc_cs_n, rtc_cs_n, rtc_ale, xdir_n, xoe_n},
          7'b1111011);

      // R1 R4 R6: I/O sweep, reads and writes, upper bit clear and set
      for (int up = 0; up < 2; up++)
         for (int rw = 0; rw < 2; rw++)
            for (int a = 0; a < 256; a++) begin
               logic [15:0] io; logic k, m, r, any;
               @(negedge clk);
               io = 16'(a) | (up != 0 ? 16'h0100 : 16'h0000);
               sa = {1'b0, io}; la = '0;
               ior_n = (rw == 0) ? 1'b0 : 1'b1;
               iow_n = (rw == 0) ? 1'b1 : 1'b0;
               #1;
               k = (io == 16'h60) || (io == 16'h64);
               m = (io == 16'h62) || (io == 16'h66);
               r = (io == 16'h71);
               any = k | m | r;
               chk("R1", {4'b0, kbc_cs_n, mc_cs_n, rtc_cs_n}, {4'b0, !k, !m, !r});
               chk("R4", {6'b0, xdir_n}, {6'b0, rw != 0});
               chk("R6", {6'b0, xoe_n}, {6'b0, !any});
               @(negedge clk); ior_n = 1; iow_n = 1;
               repeat (2) @(negedge clk);  // let any index strobe expire
            end

      // R1: upper bits above 15 must be zero
      @(negedge clk); sa = 17'h10060; ior_n = 0; #1;
      chk("R1 sa16", {6'b0, kbc_cs_n}, 7'd1);
      sa = 17'h00060; la = 7'h01; #1;
      chk("R1 la", {6'b0, kbc_cs_n}, 7'd1);
      la = 0; ior_n = 1;

      // R1 R6: disabled devices get no select and no enable
      for (int d = 1; d < 4; d++) begin
         @(negedge clk);
         dev_en = 4'hF & ~(4'd1 << d);
         sa = (d == 1) ? 17'h64 : (d == 2) ? 17'h66 : 17'h71;
         iow_n = 0; #1;
         chk("R1 disabled", {4'b0, kbc_cs_n, mc_cs_n, rtc_cs_n}, 7'b0000111);
         chk("R6 disabled", {6'b0, xoe_n}, 7'd1);
         @(negedge clk); iow_n = 1;
         repeat (2) @(negedge clk);
      end
      dev_en = 4'hF;

      // R3 R4: memory sweep over LA, SA16, range option and command
      for (int w = 0; w < 2; w++)
         for (int l = 0; l < 128; l++)
            for (int s = 0; s < 2; s++)
               for (int c = 0; c < 2; c++) begin
                  logic e;
                  @(negedge clk);
                  bios_wide = w[0]; la = 7'(l); sa = {s[0], 16'h1234};
                  memr_n = (c == 0) ? 1'b0 : 1'b1;
                  memw_n = (c == 0) ? 1'b1 : 1'b0;
                  #1;
                  e = bios_exp(7'(l), s[0], w[0]);
                  chk("R3", {6'b0, bios_cs_n}, {6'b0, !e});
                  chk("R4 mem", {6'b0, xdir_n}, {6'b0, !(e && c == 0)});
                  memr_n = 1; memw_n = 1;
               end

      // R3: firmware decode disabled
      @(negedge clk); la = 7'h07; sa = 17'h10000; memr_n = 0; dev_en = 4'hE; #1;
      chk("R3 disabled", {5'b0, bios_cs_n, xdir_n}, 7'b0000011);
      dev_en = 4'hF;
      // R3 R5: DMA suppresses the firmware select, direction follows DACK
      dma_act = 1; #1;
      chk("R3 dma", {6'b0, bios_cs_n}, 7'd1);
      chk("R5 dack high", {6'b0, xdir_n}, 7'd1);
      dack_n = 0; #1;
      chk("R5 dack low", {6'b0, xdir_n}, 7'd0);
      dack_n = 1; #1;
      chk("R5 dack rise", {6'b0, xdir_n}, 7'd1);
      memr_n = 1; dma_act = 0; la = 0; sa = 0;

      // R2: index write gives a two-cycle strobe
      @(negedge clk); sa = 17'h70; iow_n = 0;
      #1; chk("R2 before edge", {6'b0, rtc_ale}, 7'd0);
      @(negedge clk); chk("R2 cycle1", {6'b0, rtc_ale}, 7'd1);
      iow_n = 1;
      @(negedge clk); chk("R2 cycle2", {6'b0, rtc_ale}, 7'd1);
      @(negedge clk); chk("R2 end", {6'b0, rtc_ale}, 7'd0);
      // R2: data port write gives no strobe
      sa = 17'h71; iow_n = 0;
      @(negedge clk); chk("R2 other port", {6'b0, rtc_ale}, 7'd0);
      iow_n = 1;

      // R7: PCI cycle releases at command end
      @(negedge clk); isa_master = 0; sa = 17'h60; ior_n = 0;
      @(negedge clk); chk("R7 pci active", {6'b0, xoe_n}, 7'd0);
      ior_n = 1; #1;
      chk("R7 pci release", {6'b0, xoe_n}, 7'd1);
      // R7: ISA master holds until the address leaves
      @(negedge clk); isa_master = 1; ior_n = 0;
      @(negedge clk); ior_n = 1; #1;
      chk("R7 isa hold", {6'b0, xoe_n}, 7'd0);
      @(negedge clk); chk("R7 isa hold2", {6'b0, xoe_n}, 7'd0);
      sa = 17'h50; #1;
      chk("R7 isa release", {6'b0, xoe_n}, 7'd1);
      @(negedge clk); sa = 17'h60; #1;
      chk("R7 no rehold", {6'b0, xoe_n}, 7'd1);
      isa_master = 0; sa = 0;

      // R8: every pin value under full takeover, then per-pin select
      for (int v = 0; v < 32; v++) begin
         @(negedge clk); gpo_sel = 5'h1F; gpo_val = 5'(v); #1;
         chk("R8", {2'b0, xoe_n, xdir_n, kbc_cs_n, rtc_cs_n, rtc_ale}, {2'b0, 5'(v)});
      end
      for (int p = 0; p < 5; p++) begin
         @(negedge clk); gpo_sel = 5'(1 << p); gpo_val = ~5'b11110; #1;
         chk("R8 single", {2'b0, xoe_n, xdir_n, kbc_cs_n, rtc_cs_n, rtc_ale},
             {2'b0, 5'b11110 ^ 5'(1 << p)});
      end
      gpo_sel = 0;

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule